// File: doc/BRIEF.md
# SPI NOR Flash Programming Sequencer

This block writes a boot image into a single-bit SPI NOR flash with no processor involved. A one-cycle `start` pulse runs a fixed provisioning script, and no options change it:
1. Wait until the flash is not busy.
2. Read the device identity.
3. Reset the device.
4. Clear the block protection.
5. Erase the boot sector at address zero, then a run of 64 KiB code sectors starting at 0x010000.
6. Program the page data.
7. Ask for a hard reset so the chip boots from the new image.

The page data comes from two byte-addressed source regions through a read port with no latency. Region 0 holds the first-stage image of `STAGE_PAGES` pages, which are written from flash address 0. Region 1 holds the code bytes. These are written from 0x010000 behind a four-byte length header, and the block builds that header itself from `code_len`.

The serial side runs in mode 0 and sends every byte MSB first. The half-period of SCK is `HALF_CYC` clock cycles. The fixed waits of 2 µs and 50 µs are counted in multiples of `US_CYC`, the number of clock cycles in one microsecond. After every write-type command the block repeats a status read until the write-in-progress bit clears.

Top module: `spi_flash_provisioner`

## Requirements
- R1: SCK is low whenever CS is high. MOSI changes only while SCK is low, and each byte is sent MSB first. Between two frames CS stays high for at least one SCK period (2*HALF_CYC cycles).
- R2: A `start` pulse while idle launches the script, and `done` falls. A `start` pulse during a run has no effect: it changes neither the frames nor the latched length. At completion `reboot_req` is high for exactly one cycle, on the same edge at which `done` rises. `done` then stays high until the next accepted start.
- R3: The reset phase sends these frames in order, each as its own frame:
  - a busy poll;
  - 0xAB with three 0x00 address bytes and one read byte, sent as 0x00;
  - 0x66, after a pause of at least 2*US_CYC cycles;
  - 0x99;
  - 0x06, after a pause of at least 50*US_CYC cycles;
  - 0x98;
  - a busy poll.
- R4: A busy poll is the frame {0x05, 0x00}. MISO is sampled on each rising SCK edge, MSB first. The poll is repeated while bit 0 of the received byte is 1, and the script continues once that bit is 0.
- R5: Each erase is a 0x06 frame, then the frame {0xD8, A[23:16], A[15:8], A[7:0]}, then a busy poll. The erased sectors are 0x000000 first, then CODE_SECTORS sectors at 0x010000, 0x020000, and onward in steps of 0x10000.
- R6: Each page write is a 0x06 frame, then one frame of 0x02, the three address bytes MSB first and exactly 256 data bytes, then a busy poll. Each following page address is 256 higher.
- R7: The first-stage pages come first. There are STAGE_PAGES of them, starting at flash 0, and flash byte k is taken from region 0 at address k.
- R8: The code pages start at 0x010000, and their number is (code_len >> 8) + 2. Code byte k for k < 4 is byte k of code_len, least significant byte first, with byte 3 equal to 0x00. For k >= 4 it is region 1 at address k-4.
- R9: After the last page's busy poll finds the flash idle, at least 2*US_CYC cycles pass before `reboot_req`. CS stays high while `done` is high.
- R10: After reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, and both `done` and `reboot_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the script |
| code_len | input | 24 | Code length in bytes, latched when a start is accepted |
| src_region | output | 1 | Source region select: 0 first-stage image, 1 code image |
| src_addr | output | SRC_AW | Byte address in the selected region |
| src_byte | input | 8 | Source byte returned in the same cycle |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| done | output | 1 | High once the script has completed |
| reboot_req | output | 1 | One-cycle hard-reset request at completion |

## Verification
The assertions take for granted that `src_byte` is a pure function of the source address in the same cycle. They also assume that MISO changes only after a falling SCK edge or while CS is high, and that `start` is a clean single-cycle pulse. The bench flash model drives MISO only at the clock phase that follows a falling SCK edge. It reports busy for a fixed number of polls after each erase or page command, so the exact count of repeated polls is known in advance. The bench pulses `start` in the middle of a run with a different length, which checks that the latched length is kept.

// File: rtl/spi_flash_provisioner.sv
module spi_flash_provisioner #(
  parameter int HALF_CYC     = 2,
  parameter int US_CYC       = 50,
  parameter int SRC_AW       = 16,
  parameter int STAGE_PAGES  = 4,
  parameter int CODE_SECTORS = 8,
  parameter logic [23:0] CODE_BASE = 24'h010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       code_len,
  output logic              src_region,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [7:0]        src_byte,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              done,
  output logic              reboot_req
);
  localparam int HW  = $clog2(2*HALF_CYC+1);
  localparam int W2  = 2*US_CYC;
  localparam int W50 = 50*US_CYC;
  localparam int DW  = $clog2(W50+1);
  localparam int SW  = $clog2(CODE_SECTORS+1);

  typedef enum logic [4:0] {
    PH_IDLE, PH_POLL0, PH_ID, PH_W2, PH_RSTEN, PH_RST, PH_W50, PH_WEN, PH_UNLK,
    PH_POLL1, PH_EWEN, PH_ERASE, PH_EPOLL, PH_PWEN, PH_PROG, PH_PPOLL, PH_WEND, PH_FIN
  } phase_t;
  typedef enum logic [1:0] {F_IDLE, F_BIT, F_TAIL, F_GAP} fst_t;

  phase_t phase;
  fst_t   fst;
  logic [HW-1:0] hcnt;
  logic [2:0]    bitn;
  logic [8:0]    bidx;
  logic [7:0]    txsh, rxsh;
  logic [DW-1:0] dcnt;
  logic [SW-1:0] sec;
  logic [16:0]   pleft, cpages;
  logic [23:0]   poff;
  logic [31:0]   len_q;
  logic          region;

  logic [7:0]  opcode, nbyte, pdata;
  logic [8:0]  flen, nidx;
  logic [23:0] off, faddr, ea;
  logic        is_frame, is_poll, fdone, half_t;

  always_comb begin
    opcode = 8'h00;
    flen   = 9'd1;
    unique case (phase)
      PH_POLL0, PH_POLL1, PH_EPOLL, PH_PPOLL: begin opcode = 8'h05; flen = 9'd2; end
      PH_ID:    begin opcode = 8'hAB; flen = 9'd5; end
      PH_RSTEN: opcode = 8'h66;
      PH_RST:   opcode = 8'h99;
      PH_WEN, PH_EWEN, PH_PWEN: opcode = 8'h06;
      PH_UNLK:  opcode = 8'h98;
      PH_ERASE: begin opcode = 8'hD8; flen = 9'd4; end
      PH_PROG:  begin opcode = 8'h02; flen = 9'd260; end
      default:  ;
    endcase
  end

  assign is_poll  = phase inside {PH_POLL0, PH_POLL1, PH_EPOLL, PH_PPOLL};
  assign is_frame = is_poll || (phase inside {PH_ID, PH_RSTEN, PH_RST, PH_WEN, PH_UNLK,
                                              PH_EWEN, PH_ERASE, PH_PWEN, PH_PROG});
  assign half_t = hcnt == HW'(HALF_CYC-1);
  assign fdone  = (fst == F_GAP) && (hcnt == HW'(2*HALF_CYC-1));

  assign nidx  = bidx + 9'd1;
  assign off   = poff + 24'(nidx) - 24'd4;
  assign ea    = (sec == '0) ? 24'h0 : (24'(sec) << 16);
  assign faddr = (phase == PH_ERASE) ? ea :
                 (phase == PH_PROG)  ? (region ? CODE_BASE + poff : poff) : 24'h0;

  assign src_region = region;
  assign src_addr   = region ? SRC_AW'(off - 24'd4) : SRC_AW'(off);
  assign pdata      = (region && off < 24'd4) ? len_q[{off[1:0], 3'b000} +: 8] : src_byte;

  always_comb begin
    unique case (nidx)
      9'd1:    nbyte = faddr[23:16];
      9'd2:    nbyte = faddr[15:8];
      9'd3:    nbyte = faddr[7:0];
      default: nbyte = (phase == PH_PROG) ? pdata : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; fst <= F_IDLE;
      cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0;
      hcnt <= '0; bitn <= '0; bidx <= '0; txsh <= '0; rxsh <= '0;
      dcnt <= '0; sec <= '0; pleft <= '0; cpages <= '0; poff <= '0;
      len_q <= '0; region <= 1'b0; done <= 1'b0; reboot_req <= 1'b0;
    end else begin
      reboot_req <= 1'b0;

      unique case (fst)
        F_IDLE: if (is_frame) begin
          cs_n <= 1'b0; mosi <= opcode[7]; txsh <= {opcode[6:0], 1'b0};
          bidx <= '0; bitn <= '0; hcnt <= '0; fst <= F_BIT;
        end
        F_BIT: if (half_t) begin
          hcnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            rxsh <= {rxsh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              bitn <= '0;
              if (bidx == flen - 9'd1) fst <= F_TAIL;
              else begin
                bidx <= nidx; mosi <= nbyte[7]; txsh <= {nbyte[6:0], 1'b0};
              end
            end else begin
              bitn <= bitn + 3'd1; mosi <= txsh[7]; txsh <= {txsh[6:0], 1'b0};
            end
          end
        end else hcnt <= hcnt + HW'(1);
        F_TAIL: if (half_t) begin
          cs_n <= 1'b1; mosi <= 1'b0; hcnt <= '0; fst <= F_GAP;
        end else hcnt <= hcnt + HW'(1);
        F_GAP: if (fdone) begin
          hcnt <= '0; fst <= F_IDLE;
        end else hcnt <= hcnt + HW'(1);
        default: fst <= F_IDLE;
      endcase

      unique case (phase)
        PH_IDLE: if (start) begin
          len_q  <= {8'h00, code_len};
          cpages <= {1'b0, code_len[23:8]} + 17'd2;
          done   <= 1'b0;
          phase  <= PH_POLL0;
        end
        PH_POLL0: if (fdone && !rxsh[0]) phase <= PH_ID;
        PH_ID:    if (fdone) begin dcnt <= DW'(W2-1); phase <= PH_W2; end
        PH_W2:    if (dcnt == '0) phase <= PH_RSTEN; else dcnt <= dcnt - DW'(1);
        PH_RSTEN: if (fdone) phase <= PH_RST;
        PH_RST:   if (fdone) begin dcnt <= DW'(W50-1); phase <= PH_W50; end
        PH_W50:   if (dcnt == '0) phase <= PH_WEN; else dcnt <= dcnt - DW'(1);
        PH_WEN:   if (fdone) phase <= PH_UNLK;
        PH_UNLK:  if (fdone) phase <= PH_POLL1;
        PH_POLL1: if (fdone && !rxsh[0]) begin sec <= '0; phase <= PH_EWEN; end
        PH_EWEN:  if (fdone) phase <= PH_ERASE;
        PH_ERASE: if (fdone) phase <= PH_EPOLL;
        PH_EPOLL: if (fdone && !rxsh[0]) begin
          if (sec == SW'(CODE_SECTORS)) begin
            region <= 1'b0; poff <= '0; pleft <= 17'(STAGE_PAGES); phase <= PH_PWEN;
          end else begin
            sec <= sec + SW'(1); phase <= PH_EWEN;
          end
        end
        PH_PWEN:  if (fdone) phase <= PH_PROG;
        PH_PROG:  if (fdone) phase <= PH_PPOLL;
        PH_PPOLL: if (fdone && !rxsh[0]) begin
          if (pleft == 17'd1) begin
            if (region) begin
              dcnt <= DW'(W2-1); phase <= PH_WEND;
            end else begin
              region <= 1'b1; poff <= '0; pleft <= cpages; phase <= PH_PWEN;
            end
          end else begin
            pleft <= pleft - 17'd1; poff <= poff + 24'd256; phase <= PH_PWEN;
          end
        end
        PH_WEND:  if (dcnt == '0) phase <= PH_FIN; else dcnt <= dcnt - DW'(1);
        PH_FIN: begin
          done <= 1'b1; reboot_req <= 1'b1; region <= 1'b0; phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_provisioner_chk.sv
module spi_flash_provisioner_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic reboot_req
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R1
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck)) |-> $stable(mosi)); // R1
  AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req); // R2
  AST_DONE_WITH_REBOOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> reboot_req); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R2
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !sck)); // R9
endmodule

bind spi_flash_provisioner spi_flash_provisioner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sck(sck),
  .mosi(mosi), .done(done), .reboot_req(reboot_req)
);

// File: tb/tb_spi_flash_provisioner.sv
`timescale 1ns/1ps
module tb_spi_flash_provisioner;
  localparam int HALF = 1;
  localparam int US   = 50;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] code_len = '0;
  logic src_region;
  logic [15:0] src_addr;
  logic [7:0] src_byte;
  logic cs_n, sck, mosi, done, reboot_req;
  logic miso = 1'b0;

  always #10 clk = ~clk;

  spi_flash_provisioner #(.HALF_CYC(HALF), .US_CYC(US)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_len(code_len),
    .src_region(src_region), .src_addr(src_addr), .src_byte(src_byte),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .done(done), .reboot_req(reboot_req));

  function automatic logic [7:0] img(input logic reg1, input logic [15:0] a);
    if (!reg1) return 8'(a[7:0] + {6'b0, a[9:8]} * 8'd37);
    return 8'((a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5);
  endfunction

  always_comb src_byte = img(src_region, src_addr);

  int nchecks = 0;
  int nerrors = 0;
  logic [8:0] expq[$];
  string tagq[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input string tag);
    expq.push_back({1'b0, b}); tagq.push_back(tag);
  endtask
  task automatic endf(input string tag);
    expq.push_back(9'h100); tagq.push_back(tag);
  endtask
  task automatic one(input logic [7:0] b, input string tag);
    put(b, tag); endf(tag);
  endtask
  task automatic polls(input int n);
    for (int i = 0; i < n; i++) begin put(8'h05, "R4"); put(8'h00, "R4"); endf("R4"); end
  endtask
  task automatic page(input logic [23:0] a, input logic reg1, input int base,
                      input logic [23:0] len);
    one(8'h06, "R6");
    put(8'h02, "R6"); put(a[23:16], "R6"); put(a[15:8], "R6"); put(a[7:0], "R6");
    for (int k = 0; k < 256; k++) begin
      int o = base + k;
      if (!reg1) put(img(1'b0, 16'(o)), "R7");
      else if (o < 4) put((o == 3) ? 8'h00 : 8'(len >> (8*o)), "R8");
      else put(img(1'b1, 16'(o - 4)), "R8");
    end
    endf("R6");
    polls(3);
  endtask

  task automatic build_run(input logic [23:0] len);
    polls(2);
    put(8'hAB, "R3"); for (int i = 0; i < 4; i++) put(8'h00, "R3"); endf("R3");
    one(8'h66, "R3"); one(8'h99, "R3"); one(8'h06, "R3"); one(8'h98, "R3");
    polls(1);
    for (int s = 0; s <= 8; s++) begin
      logic [23:0] a = 24'(s) << 16;
      one(8'h06, "R5");
      put(8'hD8, "R5"); put(a[23:16], "R5"); put(a[15:8], "R5"); put(a[7:0], "R5"); endf("R5");
      polls(3);
    end
    for (int p = 0; p < 4; p++) page(24'(p*256), 1'b0, p*256, len);
    for (int p = 0; p < int'(len >> 8) + 2; p++)
      page(24'h010000 + 24'(p*256), 1'b1, p*256, len);
  endtask

  // monitor and flash model
  logic pcs = 1'b1, psck = 1'b0;
  int cyc = 0, last_end = -1, gap = 0, nbits = 0, nbytes = 0;
  int busy_left = 1, reboot_cnt = 0;
  logic [7:0] sh = '0, op = '0, prev_op = '0, resp = '0;

  task automatic got(input logic [8:0] item);
    logic [8:0] e;
    string t;
    if (expq.size() == 0) begin
      check(1'b0, "R2", "unexpected extra item", item, 9'h1FF);
      return;
    end
    e = expq.pop_front(); t = tagq.pop_front();
    check(item == e, t, "frame item", item, e);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pcs && !cs_n) begin
      nbits = 0; nbytes = 0; miso <= 1'b0; resp = '0;
      gap = cyc - last_end;
      if (last_end >= 0) check(gap >= 2*HALF, "R1", "CS high time", gap, 2*HALF);
    end
    if (!cs_n && sck && !psck) begin
      sh = {sh[6:0], mosi};
      nbits++;
      if (nbits % 8 == 0) begin
        got({1'b0, sh});
        if (nbytes == 0) begin
          op = sh;
          if (op == 8'h66) check(gap >= 2*US, "R3", "pause before 0x66", gap, 2*US);
          if (op == 8'h06 && prev_op == 8'h99)
            check(gap >= 50*US, "R3", "pause after 0x99", gap, 50*US);
          if (op == 8'h05) begin
            resp = (busy_left > 0) ? 8'h01 : 8'h00;
            if (busy_left > 0) busy_left--;
          end
          if (op == 8'hAB) resp = 8'h17;
        end
        nbytes++;
      end
    end
    if (!cs_n && !sck && psck && nbytes >= 1) begin
      miso <= resp[7];
      resp = {resp[6:0], 1'b0};
    end
    if (!pcs && cs_n) begin
      got(9'h100);
      if (op == 8'hD8 || op == 8'h02) busy_left = 2;
      last_end = cyc; prev_op = op; miso <= 1'b0;
    end
    if (reboot_req) begin
      reboot_cnt++;
      check(cyc - last_end >= 2*US, "R9", "pause before reboot", cyc - last_end, 2*US);
      check(done == 1'b1, "R2", "done with reboot", done, 1);
      busy_left = 1;
    end
    pcs = cs_n; psck = sck;
  end

  task automatic run(input logic [23:0] len, output bit ok);
    int r0 = reboot_cnt;
    int waited = 0;
    build_run(len);
    code_len = len; start = 1'b1;
    @(negedge clk); start = 1'b0;
    code_len = 24'hFFFFFF;
    repeat (3000) @(negedge clk);
    check(done == 1'b0, "R2", "done low during run", done, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (reboot_cnt == r0 && waited < LIMIT) begin @(negedge clk); waited++; end
    ok = (reboot_cnt != r0);
    check(ok, "R2", "watchdog: run completed", waited, LIMIT);
    if (!ok) return;
    check(expq.size() == 0, "R2", "all expected frames seen", expq.size(), 0);
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R2", "done holds", done, 1);
    check(cs_n == 1'b1, "R9", "CS idle after done", cs_n, 1);
    check(reboot_cnt == r0 + 1, "R2", "single reboot pulse", reboot_cnt, r0 + 1);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R10", "cs_n in reset", cs_n, 1);
    check(sck == 1'b0, "R10", "sck in reset", sck, 0);
    check(mosi == 1'b0, "R10", "mosi in reset", mosi, 0);
    check(done == 1'b0, "R10", "done in reset", done, 0);
    check(reboot_req == 1'b0, "R10", "reboot in reset", reboot_req, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(24'd300, ok);
    if (ok) run(24'd0, ok);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule